// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block computes the memory address of a data operand for a processor that supports segmented addressing. Each request supplies two general-register values (a base and an index) with their register-select codes, a two-bit index scale, a signed 32-bit displacement, four segment register values, the instruction pointer, an addressing mode and an access size. The block adds the enabled components and wraps the sum to the width of the mode. It picks a segment, either the default implied by the base register or an explicit override. It then forms either a real-mode physical address or a flat linear address.

Four modes are supported. Mode 0 uses 16-bit offsets with real-mode segmentation. Mode 1 uses 32-bit offsets with a shifted segment added. Mode 2 is flat 64-bit, where the register sum is itself the linear address. Mode 3 is instruction-pointer-relative, where a sign-extended displacement is added to the 64-bit instruction pointer. The block flags register combinations that the mode does not allow, and it flags accesses that are not aligned to their size. Every result is registered and qualified by a valid bit one cycle after the request.

Top module: `seg_ea_gen`

## Requirements
- R1: In mode 0, out_addr = (segment value × 16 + 16-bit offset) modulo 2^20, zero-extended to 64 bits; for example, segment 1000H with offset 1234H gives 11234H.
- R2: The offset is the sum of base (when base_en), index × scale (when index_en) and the sign-extended displacement (when disp_en), taken modulo 2^16 in mode 0, modulo 2^32 in mode 1 and modulo 2^64 in mode 2; it appears on out_offset.
- R3: Without an override, out_seg is SS (code 2) when base_en is set and base_sel is 5 (the frame-pointer register), and DS (code 3) otherwise; the segment codes are ES=0, CS=1, SS=2, DS=3.
- R4: When seg_ovr_en is high, the segment coded on seg_ovr_sel replaces the default, both on out_seg and in the address.
- R5: The index is multiplied by 1, 2, 4 or 8 for scale codes 0, 1, 2 and 3.
- R6: In mode 0, out_illegal is set when an enabled base is not code 3 or 5, when an enabled index is not code 6 or 7, or when an enabled index has a scale code other than 0.
- R7: In modes 1 and 2, out_illegal is set when an enabled base or an enabled index selects code 4 (the stack pointer); any other code is allowed.
- R8: In mode 3, out_addr = out_offset = instruction pointer + sign-extended displacement modulo 2^64. Base, index, disp_en and the segment registers have no effect, and out_illegal is 0.
- R9: In mode 2, out_addr equals out_offset and the segment registers have no effect.
- R10: out_size is 1 << size_code (1, 2, 4 or 8 bytes), and out_misalign is set when out_addr is not a multiple of out_size.
- R11: Outputs update on the clock edge that samples in_valid high, and out_valid is high for exactly the cycle after that edge. When in_valid is low, the address outputs hold. An active-low synchronous reset clears out_valid and all outputs.
- R12: In mode 1, out_addr = (segment value × 16 + 32-bit offset) modulo 2^32, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 real 16-bit, 1 segmented 32-bit, 2 flat 64-bit, 3 IP-relative |
| base_en | input | 1 | Include base value |
| base_sel | input | 3 | Base register code |
| base_val | input | 64 | Base register contents |
| index_en | input | 1 | Include scaled index value |
| index_sel | input | 3 | Index register code |
| index_val | input | 64 | Index register contents |
| scale | input | 2 | Index scale code |
| disp_en | input | 1 | Include displacement |
| disp | input | 32 | Signed displacement |
| ip | input | 64 | Instruction pointer |
| seg_ovr_en | input | 1 | Segment override enable |
| seg_ovr_sel | input | 2 | Override segment code |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| size_code | input | 2 | Access size code |
| out_valid | output | 1 | Result valid |
| out_offset | output | 64 | Wrapped effective offset |
| out_seg | output | 2 | Chosen segment code |
| out_addr | output | 64 | Physical or linear address |
| out_size | output | 4 | Access size in bytes |
| out_illegal | output | 1 | Disallowed register combination |
| out_misalign | output | 1 | Address not aligned to size |

## Verification
The datapath holds no state beyond the output register, so an error in the segment choice, the wrap width or the scale shift shows up on out_addr, out_seg or out_offset in the very cycle after the faulty request. The same applies to the legality and alignment flags. A fault in the output register's enable shows up as a changed address, or a stray out_valid, one cycle after a cycle with in_valid low. Directed requests cover the 20-bit wrap, override against default, stack-pointer rejection and negative IP-relative displacements. Random requests then cover the mixes of modes and enables.

// File: rtl/ea_pkg.sv
// Shared encodings for the effective address generator.
// Assumes register codes follow the usual 3-bit general register numbering.
package ea_pkg;
    typedef enum logic [1:0] {
        MODE_R16   = 2'd0,
        MODE_R32   = 2'd1,
        MODE_FLAT  = 2'd2,
        MODE_IPREL = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        SEG_E = 2'd0,
        SEG_C = 2'd1,
        SEG_S = 2'd2,
        SEG_D = 2'd3
    } seg_id_e;

    localparam logic [2:0] RC_SP = 3'd4;
    localparam logic [2:0] RC_BX = 3'd3;
    localparam logic [2:0] RC_BP = 3'd5;
    localparam logic [2:0] RC_SI = 3'd6;
    localparam logic [2:0] RC_DI = 3'd7;
endpackage

// File: rtl/ea_offset_calc.sv
// Sums the enabled offset components and wraps the sum to the mode width.
// Assumes XLEN >= 32; in IP-relative mode only ip and disp are used.
module ea_offset_calc
    import ea_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int OFF_S = 16,
    parameter int OFF_M = 32
) (
    input  ea_mode_e          mode,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic              index_en,
    input  logic [XLEN-1:0]   index_val,
    input  logic [1:0]        scale,
    input  logic              disp_en,
    input  logic [31:0]       disp,
    input  logic [XLEN-1:0]   ip,
    output logic [XLEN-1:0]   offset
);
    localparam int SX = XLEN - 32;

    logic [XLEN-1:0] disp_x;
    logic [XLEN-1:0] sum;

    // Sign-extend displacement and add the enabled components.
    always_comb begin
        disp_x = {{SX{disp[31]}}, disp};
        sum = (base_en ? base_val : '0)
            + (index_en ? (index_val << scale) : '0)
            + (disp_en ? disp_x : '0);
    end

    // Wrap the sum to the width of the mode.
    always_comb begin
        unique case (mode)
            MODE_R16:   offset = {{(XLEN-OFF_S){1'b0}}, sum[OFF_S-1:0]};
            MODE_R32:   offset = {{(XLEN-OFF_M){1'b0}}, sum[OFF_M-1:0]};
            MODE_FLAT:  offset = sum;
            default:    offset = ip + disp_x;
        endcase
    end
endmodule

// File: rtl/ea_seg_select.sv
// Chooses the segment (default from the base register, or an override)
// and checks the register combination allowed by the mode.
// Assumes register codes from ea_pkg.
module ea_seg_select
    import ea_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  ea_mode_e           mode,
    input  logic               base_en,
    input  logic [2:0]         base_sel,
    input  logic               index_en,
    input  logic [2:0]         index_sel,
    input  logic [1:0]         scale,
    input  logic               ovr_en,
    input  logic [1:0]         ovr_sel,
    input  logic [SEG_W-1:0]   seg_es,
    input  logic [SEG_W-1:0]   seg_cs,
    input  logic [SEG_W-1:0]   seg_ss,
    input  logic [SEG_W-1:0]   seg_ds,
    output seg_id_e            seg_id,
    output logic [SEG_W-1:0]   seg_val,
    output logic               illegal
);
    // Default segment from the base register, unless overridden.
    always_comb begin
        if (ovr_en)
            seg_id = seg_id_e'(ovr_sel);
        else if (base_en && base_sel == RC_BP)
            seg_id = SEG_S;
        else
            seg_id = SEG_D;
    end

    // Fetch the value of the chosen segment register.
    always_comb begin
        unique case (seg_id)
            SEG_E:   seg_val = seg_es;
            SEG_C:   seg_val = seg_cs;
            SEG_S:   seg_val = seg_ss;
            default: seg_val = seg_ds;
        endcase
    end

    // Flag register combinations that the mode does not permit.
    always_comb begin
        unique case (mode)
            MODE_R16: illegal =
                (base_en  && base_sel != RC_BX && base_sel != RC_BP) ||
                (index_en && index_sel != RC_SI && index_sel != RC_DI) ||
                (index_en && scale != 2'd0);
            MODE_R32,
            MODE_FLAT: illegal =
                (base_en && base_sel == RC_SP) || (index_en && index_sel == RC_SP);
            default:   illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ea_addr_form.sv
// Applies the segment base (real or 32-bit segmented) or passes the flat
// offset, then derives the access size and misalignment flag.
module ea_addr_form
    import ea_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEG_W = 16,
    parameter int OFF_M = 32
) (
    input  ea_mode_e          mode,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [XLEN-1:0]   offset,
    input  logic [1:0]        size_code,
    output logic [XLEN-1:0]   addr,
    output logic [3:0]        size_bytes,
    output logic              misalign
);
    localparam int REAL_W = SEG_W + 4;

    logic [REAL_W-1:0] real_addr;
    logic [OFF_M-1:0]  seg32_addr;
    logic [2:0]        low_mask;

    // Shifted segment plus offset, wrapped to each segmented width.
    always_comb begin
        real_addr  = {seg_val, 4'b0} + REAL_W'(offset[SEG_W-1:0]);
        seg32_addr = OFF_M'({seg_val, 4'b0}) + offset[OFF_M-1:0];
    end

    // Select the address form by mode.
    always_comb begin
        unique case (mode)
            MODE_R16: addr = {{(XLEN-REAL_W){1'b0}}, real_addr};
            MODE_R32: addr = {{(XLEN-OFF_M){1'b0}}, seg32_addr};
            default:  addr = offset;
        endcase
    end

    // Size in bytes and the low-address bits that must be zero.
    always_comb begin
        size_bytes = 4'd1 << size_code;
        unique case (size_code)
            2'd0:    low_mask = 3'b000;
            2'd1:    low_mask = 3'b001;
            2'd2:    low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
        misalign = |(addr[2:0] & low_mask);
    end
endmodule

// File: rtl/seg_ea_gen.sv
// Top of the effective address generator: combinational offset, segment
// and address stages feed one output register qualified by out_valid.
// Assumes the caller holds inputs stable around the sampling edge.
module seg_ea_gen
    import ea_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              base_en,
    input  logic [2:0]        base_sel,
    input  logic [XLEN-1:0]   base_val,
    input  logic              index_en,
    input  logic [2:0]        index_sel,
    input  logic [XLEN-1:0]   index_val,
    input  logic [1:0]        scale,
    input  logic              disp_en,
    input  logic [31:0]       disp,
    input  logic [XLEN-1:0]   ip,
    input  logic              seg_ovr_en,
    input  logic [1:0]        seg_ovr_sel,
    input  logic [SEG_W-1:0]  seg_es,
    input  logic [SEG_W-1:0]  seg_cs,
    input  logic [SEG_W-1:0]  seg_ss,
    input  logic [SEG_W-1:0]  seg_ds,
    input  logic [1:0]        size_code,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_offset,
    output logic [1:0]        out_seg,
    output logic [XLEN-1:0]   out_addr,
    output logic [3:0]        out_size,
    output logic              out_illegal,
    output logic              out_misalign
);
    localparam int OFF_S = SEG_W;
    localparam int OFF_M = 2 * SEG_W;

    ea_mode_e         mode_e;
    ea_mode_e         mode_q;
    logic [XLEN-1:0]  offset_c;
    seg_id_e          seg_id_c;
    logic [SEG_W-1:0] seg_val_c;
    logic             illegal_c;
    logic [XLEN-1:0]  addr_c;
    logic [3:0]       size_c;
    logic             misalign_c;

    assign mode_e = ea_mode_e'(mode);

    ea_offset_calc #(.XLEN(XLEN), .OFF_S(OFF_S), .OFF_M(OFF_M)) u_off (
        .mode(mode_e), .base_en(base_en), .base_val(base_val),
        .index_en(index_en), .index_val(index_val), .scale(scale),
        .disp_en(disp_en), .disp(disp), .ip(ip), .offset(offset_c)
    );

    ea_seg_select #(.SEG_W(SEG_W)) u_seg (
        .mode(mode_e), .base_en(base_en), .base_sel(base_sel),
        .index_en(index_en), .index_sel(index_sel), .scale(scale),
        .ovr_en(seg_ovr_en), .ovr_sel(seg_ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .seg_id(seg_id_c), .seg_val(seg_val_c), .illegal(illegal_c)
    );

    ea_addr_form #(.XLEN(XLEN), .SEG_W(SEG_W), .OFF_M(OFF_M)) u_addr (
        .mode(mode_e), .seg_val(seg_val_c), .offset(offset_c),
        .size_code(size_code), .addr(addr_c), .size_bytes(size_c),
        .misalign(misalign_c)
    );

    // Valid strobe: one cycle after each sampled request, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MODE_R16;
            out_offset   <= '0;
            out_seg      <= 2'd0;
            out_addr     <= '0;
            out_size     <= 4'd0;
            out_illegal  <= 1'b0;
            out_misalign <= 1'b0;
        end else if (in_valid) begin
            mode_q       <= mode_e;
            out_offset   <= offset_c;
            out_seg      <= seg_id_c;
            out_addr     <= addr_c;
            out_size     <= size_c;
            out_illegal  <= illegal_c;
            out_misalign <= misalign_c;
        end
    end
endmodule

// File: rtl/seg_ea_gen_chk.sv
// Temporal checks on the address generator's outputs, bound to the top.
module seg_ea_gen_chk
    import ea_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [XLEN-1:0] out_addr,
    input logic [XLEN-1:0] out_offset,
    input logic [3:0]      out_size,
    input logic            out_illegal,
    input logic            out_misalign,
    input ea_mode_e        mode_q
);
    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr) && $stable(out_offset));
    // R1
    real_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == MODE_R16 |-> out_addr[XLEN-1:20] == '0);
    // R8
    iprel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == MODE_IPREL |-> !out_illegal && out_addr == out_offset);
    // R9
    flat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == MODE_FLAT |-> out_addr == out_offset);
    // R10
    size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_size) == 1);
    // R10
    byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_size == 4'd1 |-> !out_misalign);
endmodule

bind seg_ea_gen seg_ea_gen_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_seg_ea_gen.sv
// Bench for seg_ea_gen: directed corner cases, then seeded random requests,
// each compared with a model computed from the requirements.
module tb_seg_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        base_en = 1'b0;
    logic [2:0]  base_sel = 3'd0;
    logic [63:0] base_val = '0;
    logic        index_en = 1'b0;
    logic [2:0]  index_sel = 3'd0;
    logic [63:0] index_val = '0;
    logic [1:0]  scale = 2'd0;
    logic        disp_en = 1'b0;
    logic [31:0] disp = '0;
    logic [63:0] ip = '0;
    logic        seg_ovr_en = 1'b0;
    logic [1:0]  seg_ovr_sel = 2'd0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic [1:0]  size_code = 2'd0;
    logic        out_valid;
    logic [63:0] out_offset;
    logic [1:0]  out_seg;
    logic [63:0] out_addr;
    logic [3:0]  out_size;
    logic        out_illegal;
    logic        out_misalign;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    seg_ea_gen dut (.*);

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Model of the requirements, written independently of the RTL.
    task automatic model(output longint unsigned e_off, output longint unsigned e_addr,
                         output int e_seg, output bit e_ill, output bit e_mis,
                         output int e_size);
        longint unsigned dx, s, sv;
        dx = longint'(signed'(disp));
        if (mode == 2'd3) begin
            e_off = ip + dx;
        end else begin
            s = 0;
            if (base_en)  s += base_val;
            if (index_en) s += index_val * (64'd1 << scale);
            if (disp_en)  s += dx;
            if (mode == 2'd0)      e_off = s & 64'hFFFF;
            else if (mode == 2'd1) e_off = s & 64'hFFFF_FFFF;
            else                   e_off = s;
        end
        if (seg_ovr_en)                     e_seg = seg_ovr_sel;
        else if (base_en && base_sel == 5)  e_seg = 2;
        else                                e_seg = 3;
        case (e_seg)
            0: sv = seg_es;
            1: sv = seg_cs;
            2: sv = seg_ss;
            default: sv = seg_ds;
        endcase
        if (mode == 2'd0)      e_addr = (sv * 16 + e_off) % 64'h10_0000;
        else if (mode == 2'd1) e_addr = (sv * 16 + e_off) % 64'h1_0000_0000;
        else                   e_addr = e_off;
        if (mode == 2'd0)
            e_ill = (base_en && !(base_sel == 3 || base_sel == 5)) ||
                    (index_en && !(index_sel == 6 || index_sel == 7)) ||
                    (index_en && scale != 0);
        else if (mode == 2'd3)
            e_ill = 0;
        else
            e_ill = (base_en && base_sel == 4) || (index_en && index_sel == 4);
        e_size = 1 << size_code;
        e_mis  = (e_addr % longint'(e_size)) != 0;
    endtask

    // Issue one request on a falling edge and check the registered result.
    task automatic run(input string tag);
        longint unsigned e_off, e_addr;
        int e_seg, e_size;
        bit e_ill, e_mis;
        @(negedge clk);
        in_valid = 1'b1;
        model(e_off, e_addr, e_seg, e_ill, e_mis, e_size);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "valid",    out_valid, 1);
        check(tag, "addr",     out_addr, e_addr);
        check(tag, "offset",   out_offset, e_off);
        check(tag, "seg",      out_seg, e_seg);
        check(tag, "illegal",  out_illegal, e_ill);
        check(tag, "size",     out_size, e_size);
        check(tag, "misalign", out_misalign, e_mis);
    endtask

    task automatic clear_req();
        base_en = 0; index_en = 0; disp_en = 0; seg_ovr_en = 0;
        scale = 0; size_code = 0; base_sel = 0; index_sel = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        longint unsigned held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "reset valid", out_valid, 0);
        check("R11", "reset addr", out_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "idle valid", out_valid, 0);

        seg_es = 16'h2000; seg_cs = 16'h3000; seg_ss = 16'h4000; seg_ds = 16'h1000;
        // R1 direct displacement: DS 1000H + 1234H -> 11234H
        clear_req(); mode = 0; disp_en = 1; disp = 32'h1234;
        run("R1");
        check("R1", "literal", out_addr, 64'h11234);
        // R3 frame-pointer base defaults to SS
        clear_req(); base_en = 1; base_sel = 5; base_val = 64'h0010; disp_en = 1; disp = 32'h4;
        run("R3");
        check("R3", "ss pick", out_seg, 2);
        // R4 override replaces default
        seg_ovr_en = 1; seg_ovr_sel = 0;
        run("R4");
        check("R4", "es addr", out_addr, 64'h20014);
        // R2 16-bit wrap of BX+SI
        clear_req(); base_en = 1; base_sel = 3; base_val = 64'hFFFF;
        index_en = 1; index_sel = 6; index_val = 64'h2;
        run("R2");
        check("R2", "wrap16", out_offset, 64'h1);
        // R1 20-bit wrap of the physical address
        seg_ds = 16'hFFFF; base_val = 64'h10; index_val = 64'h0;
        run("R1");
        check("R1", "wrap20", out_addr, 64'h0);
        seg_ds = 16'h1000;
        // R6 illegal base and scaled index in mode 0
        clear_req(); base_en = 1; base_sel = 0;
        run("R6");
        clear_req(); index_en = 1; index_sel = 7; scale = 1;
        run("R6");
        // R5 and R12 scaled index in mode 1
        clear_req(); mode = 1; seg_ds = 16'h0; base_en = 1; base_sel = 7; base_val = 64'h100;
        index_en = 1; index_sel = 1; index_val = 64'h3; scale = 2;
        run("R5");
        check("R5", "x4", out_addr, 64'h10C);
        seg_ds = 16'hFFFF; base_val = 64'hFFFF_FFF0; index_val = 0;
        run("R12");
        seg_ds = 16'h1000;
        // R7 stack-pointer as base in mode 1
        clear_req(); base_en = 1; base_sel = 4;
        run("R7");
        check("R7", "sp", out_illegal, 1);
        // R8 IP-relative, positive and negative displacement
        clear_req(); mode = 3; ip = 64'h10_0000_0000; disp = 32'h300;
        base_en = 1; base_val = 64'h5555; seg_ovr_en = 1;
        run("R8");
        check("R8", "pos", out_addr, 64'h10_0000_0300);
        disp = 32'hFFFF_FFF0;
        run("R8");
        check("R8", "neg", out_addr, 64'hF_FFFF_FFF0);
        // R9 flat mode ignores segments
        clear_req(); mode = 2; base_en = 1; base_sel = 0; base_val = 64'h1234_5678_9ABC_0000;
        index_en = 1; index_sel = 2; index_val = 64'h10; scale = 3;
        run("R9");
        // R10 misaligned dword
        clear_req(); base_en = 1; base_val = 64'h1002; size_code = 2;
        run("R10");
        check("R10", "mis", out_misalign, 1);
        // R11 hold: no request, changed inputs, address unchanged
        held = out_addr;
        base_val = 64'hDEAD;
        @(negedge clk);
        check("R11", "no valid", out_valid, 0);
        check("R11", "hold", out_addr, held);

        // Random requests.
        void'($urandom(32'h5EA1));
        for (int k = 0; k < 400; k++) begin
            mode = 2'($urandom);
            base_en = 1'($urandom); index_en = 1'($urandom); disp_en = 1'($urandom);
            base_sel = 3'($urandom); index_sel = 3'($urandom); scale = 2'($urandom);
            base_val = {32'($urandom), 32'($urandom)};
            index_val = {32'($urandom), 32'($urandom)};
            disp = 32'($urandom); ip = {32'($urandom), 32'($urandom)};
            seg_ovr_en = ($urandom % 4) == 0; seg_ovr_sel = 2'($urandom);
            seg_es = 16'($urandom); seg_cs = 16'($urandom);
            seg_ss = 16'($urandom); seg_ds = 16'($urandom);
            size_code = 2'($urandom);
            run("R2");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule